// File: doc/BRIEF.md
# Seven-Level Stacked-Carrier PWM Generator

The block drives the six gates of a modified H-bridge that makes seven output levels. Four gates sit on the bridge legs: S1 and S3 on the fast leg, S2 and S4 on the polarity leg. The other two (S5 and S6) control the auxiliary bidirectional switches that tap the capacitor divider. A free-running triangular carrier counts up and down between 0 and `CMAX`. At each carrier valley the block captures a signed reference sample. The captured magnitude is split into three bands of `CMAX` each. The band index gives the base level. Comparing the in-band remainder with the carrier decides, on every clock, between that level and the next one up. This has the same effect as three equal references that are stacked one carrier amplitude apart and take turns against one carrier.

The chosen level and the captured polarity select one row of a fixed gate table. A registered dead-time stage then drives that row. It turns gates off at once and lets new gates turn on only after a programmable number of idle clocks. The zero level follows the polarity, so the polarity-leg gates change only when the sign of the reference changes.

Top module: `mlpwm7_top`

## Requirements
- R1: While `rst_ni` is low, `gate_o` is 0. While `en_i` is low, `gate_o` is 0 from the first rising clock edge at which `en_i` is sampled low.
- R2: With a positive captured reference whose magnitude is an exact multiple of `CMAX`, the gates settle to a constant pattern. `gate_o` bit 0 is S1, bit 1 S2, bit 2 S3, bit 3 S4, bit 4 S5 and bit 5 S6. The patterns are: magnitude `CMAX` gives S6+S4 (6'b101000), `2*CMAX` gives S5+S4 (6'b011000) and `3*CMAX` gives S1+S4 (6'b001001).
- R3: For negative references whose magnitude is an exact multiple of `CMAX`, the patterns are: `CMAX` gives S5+S2 (6'b010010), `2*CMAX` gives S6+S2 (6'b100010) and `3*CMAX` gives S3+S2 (6'b000110).
- R4: A captured reference of zero gives the zero level. It is S3+S4 (6'b001100) when the last nonzero captured sample was positive, or when no nonzero sample has been captured since reset. It is S1+S2 (6'b000011) when the last nonzero sample was negative.
- R5: Magnitudes at or above `3*CMAX`, including the most negative code, saturate to the full level of their sign.
- R6: The magnitude is band·`CMAX` + r with 0 < r < `CMAX`, and the carrier period is 2·`CMAX` clocks. In steady state, the pattern of the next level up is present for 2r−2−`DEAD_CYC` clocks per period and the band's own pattern for 2·`CMAX`−2r−`DEAD_CYC` clocks, provided 2r ≥ `DEAD_CYC`+3. When 2r ≤ `DEAD_CYC`+2, the higher pattern never appears.
- R7: `ref_i` is sampled only at the carrier valley. The carrier is at 0 on the first edge with `en_i` high, and every 2·`CMAX` edges after that. A change between valleys has no effect on `gate_o` until one edge after the next valley.
- R8: No gate turns on fewer than `DEAD_CYC`+1 clocks after any gate turned off.
- R9: S1 and S3 are never on together, and S2 and S4 are never on together.
- R10: While the captured polarity is positive, S4 stays on and S2 stays off, including during dead time. While it is negative, S2 stays on and S4 stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low forces all gates off and parks the carrier at 0 |
| ref_i | input | REF_W | Signed reference sample, captured at the carrier valley |
| gate_o | output | 6 | Gate drives, bit 0 = S1 through bit 5 = S6 |

## Verification
The hardest case to reach from the ports is a mid-period reference change. The bench has to know where the carrier valley falls without seeing the carrier. It gets this from the enable edge: the carrier is parked at 0 while disabled, so the valleys fall at known multiples of 2·`CMAX` edges after the enable. The bench changes `ref_i` a few edges after one valley. It then samples just after the next valley, where the old pattern must still hold, and again after one dead time, where the new pattern must have arrived. A second hard case is the narrow-pulse case, where dead time swallows the upper level. A small remainder drives the block there, and the bench counts pattern occupancy over one carrier period.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;
  localparam int unsigned NGATE = 6;
  localparam int unsigned S1 = 0;
  localparam int unsigned S2 = 1;
  localparam int unsigned S3 = 2;
  localparam int unsigned S4 = 3;
  localparam int unsigned S5 = 4;
  localparam int unsigned S6 = 5;

  typedef logic [NGATE-1:0] gate_t;

  // level magnitude 0..3 plus sign -> switch combination
  function automatic gate_t level_gates(input logic [1:0] mag, input logic neg);
    gate_t g;
    g = '0;
    if (!neg) begin
      g[S4] = 1'b1;
      case (mag)
        2'd0: g[S3] = 1'b1;
        2'd1: g[S6] = 1'b1;
        2'd2: g[S5] = 1'b1;
        default: g[S1] = 1'b1;
      endcase
    end else begin
      g[S2] = 1'b1;
      case (mag)
        2'd0: g[S1] = 1'b1;
        2'd1: g[S5] = 1'b1;
        2'd2: g[S6] = 1'b1;
        default: g[S3] = 1'b1;
      endcase
    end
    return g;
  endfunction
endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier #(
  parameter int unsigned CMAX = 16,
  localparam int unsigned CW = $clog2(CMAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o,
  output logic          valley_o
);
  logic [CW-1:0] cnt_q;
  logic          down_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (!down_q) begin
      if (cnt_q == CW'(CMAX)) begin
        down_q <= 1'b1;
        cnt_q  <= cnt_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        down_q <= 1'b0;
        cnt_q  <= CW'(1);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign valley_o = en_i && (cnt_q == '0);

  // R6
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(CMAX));

  // R6
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |->
      ((cnt_q == $past(cnt_q) + CW'(1)) || ($past(cnt_q) == cnt_q + CW'(1))));
endmodule

// File: rtl/mlpwm_level.sv
module mlpwm_level #(
  parameter int unsigned CMAX  = 16,
  parameter int unsigned REF_W = 8,
  localparam int unsigned CW = $clog2(CMAX + 1),
  localparam int unsigned MW = REF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valley_i,
  input  logic [CW-1:0]           cnt_i,
  input  logic signed [REF_W-1:0] ref_i,
  output logic [1:0]              mag_o,
  output logic                    neg_o
);
  localparam logic [MW-1:0] BAND1 = MW'(CMAX);
  localparam logic [MW-1:0] BAND2 = MW'(2 * CMAX);
  localparam logic [MW-1:0] BAND3 = MW'(3 * CMAX);

  logic signed [REF_W-1:0] ref_q;
  logic                    neg_q;
  logic [MW-1:0]           abs_v, rem_v;
  logic [1:0]              band_v;
  logic                    up_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      neg_q <= 1'b0;
    end else if (valley_i) begin
      ref_q <= ref_i;
      if (ref_i[REF_W-1])   neg_q <= 1'b1;
      else if (ref_i != '0) neg_q <= 1'b0;
    end
  end

  always_comb begin
    abs_v = ref_q[REF_W-1] ? MW'(-ref_q) : MW'(ref_q);
    if (abs_v >= BAND3) begin
      band_v = 2'd3;
      rem_v  = '0;
    end else if (abs_v >= BAND2) begin
      band_v = 2'd2;
      rem_v  = abs_v - BAND2;
    end else if (abs_v >= BAND1) begin
      band_v = 2'd1;
      rem_v  = abs_v - BAND1;
    end else begin
      band_v = 2'd0;
      rem_v  = abs_v;
    end
    up_v  = rem_v > MW'(cnt_i);
    mag_o = band_v + {1'b0, up_v};
  end

  assign neg_o = neg_q;

  // R7
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valley_i) |-> (ref_q == $past(ref_q)));

  // R4
  zero_keeps_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valley_i) && $past(ref_i) == '0) |-> (neg_q == $past(neg_q)));
endmodule

// File: rtl/mlpwm_deadtime.sv
module mlpwm_deadtime #(
  parameter int unsigned DEAD_CYC = 2,
  localparam int unsigned DW = (DEAD_CYC > 0) ? $clog2(DEAD_CYC + 1) : 1,
  localparam int unsigned GW = $clog2(DEAD_CYC + 2)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  mlpwm_pkg::gate_t      target_i,
  output mlpwm_pkg::gate_t      gate_o
);
  import mlpwm_pkg::*;

  gate_t         gate_q, gate_d;
  logic [DW-1:0] dc_q;
  logic          off_now, allow_on;

  always_comb begin
    off_now  = |(gate_q & ~target_i);
    allow_on = !off_now && (dc_q == '0);
    if (!en_i) gate_d = '0;
    else       gate_d = (gate_q & target_i) | (allow_on ? target_i : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      dc_q   <= DW'(DEAD_CYC);
    end else begin
      gate_q <= gate_d;
      if (!en_i || off_now) dc_q <= DW'(DEAD_CYC);
      else if (dc_q != '0)  dc_q <= dc_q - 1'b1;
    end
  end

  assign gate_o = gate_q;

  // clocks since the last turn-off, saturating
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      gap_q <= GW'(DEAD_CYC);
    else if (|(gate_q & ~gate_d))     gap_q <= '0;
    else if (gap_q < GW'(DEAD_CYC))   gap_q <= gap_q + 1'b1;
  end

  // R8
  dead_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(gate_d & ~gate_q)) |-> (gap_q >= GW'(DEAD_CYC)));

  // R9
  s1_s3_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_q[S1] && gate_q[S3]));

  // R9
  s2_s4_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_q[S2] && gate_q[S4]));

  // R1
  idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (gate_q == '0));
endmodule

// File: rtl/mlpwm7_top.sv
module mlpwm7_top #(
  parameter int unsigned CMAX     = 16,
  parameter int unsigned REF_W    = 8,
  parameter int unsigned DEAD_CYC = 2,
  localparam int unsigned CW = $clog2(CMAX + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [REF_W-1:0] ref_i,
  output logic [5:0]              gate_o
);
  import mlpwm_pkg::*;

  logic [CW-1:0] cnt;
  logic          valley;
  logic [1:0]    mag;
  logic          neg;
  gate_t         target;

  mlpwm_carrier #(.CMAX(CMAX)) u_carrier (
    .clk_i, .rst_ni, .en_i,
    .cnt_o(cnt), .valley_o(valley)
  );

  mlpwm_level #(.CMAX(CMAX), .REF_W(REF_W)) u_level (
    .clk_i, .rst_ni,
    .valley_i(valley), .cnt_i(cnt), .ref_i,
    .mag_o(mag), .neg_o(neg)
  );

  assign target = level_gates(mag, neg);

  mlpwm_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk_i, .rst_ni, .en_i,
    .target_i(target), .gate_o
  );
endmodule

// File: tb/tb_mlpwm7_top.sv
module tb_mlpwm7_top;
  localparam int CLK_PERIOD = 10;
  localparam int C    = 16;
  localparam int RW   = 8;
  localparam int DEAD = 2;
  localparam int NV   = 13;

  logic clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic signed [RW-1:0] ref_i = '0;
  logic [5:0] gate_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mlpwm7_top #(.CMAX(C), .REF_W(RW), .DEAD_CYC(DEAD)) dut (
    .clk_i, .rst_ni, .en_i, .ref_i, .gate_o
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // continuous monitor for R8 / R9
  int cyc = 0, last_off = -1000, dt_viol = 0, dt_rises = 0, excl_viol = 0;
  logic [5:0] prev_g = '0;
  always @(negedge clk_i) begin
    cyc++;
    if (|(gate_o & ~prev_g)) begin
      dt_rises++;
      if (cyc - last_off < DEAD + 1) dt_viol++;
    end
    if (|(prev_g & ~gate_o)) last_off = cyc;
    if ((gate_o[0] && gate_o[2]) || (gate_o[1] && gate_o[3])) excl_viol++;
    prev_g = gate_o;
  end

  typedef struct packed {
    logic signed [7:0] r;
    logic [5:0]        lo_p;
    logic [7:0]        lo_n;
    logic [5:0]        hi_p;
    logic [7:0]        hi_n;
    logic              pos;
    logic [3:0]        rq;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{8'sd0,    6'b001100, 8'd32, 6'b101000, 8'd0, 1'b1, 4'd4},  // R4 zero, positive
    '{8'sd16,   6'b101000, 8'd32, 6'b011000, 8'd0, 1'b1, 4'd2},  // R2
    '{8'sd32,   6'b011000, 8'd32, 6'b001001, 8'd0, 1'b1, 4'd2},  // R2
    '{8'sd48,   6'b001001, 8'd32, 6'b000000, 8'd0, 1'b1, 4'd2},  // R2
    '{8'sd100,  6'b001001, 8'd32, 6'b000000, 8'd0, 1'b1, 4'd5},  // R5
    '{8'sd21,   6'b101000, 8'd20, 6'b011000, 8'd6, 1'b1, 4'd6},  // R6 r=5
    '{8'sd2,    6'b001100, 8'd29, 6'b101000, 8'd0, 1'b1, 4'd6},  // R6 narrow, swallowed
    '{-8'sd16,  6'b010010, 8'd32, 6'b100010, 8'd0, 1'b0, 4'd3},  // R3
    '{-8'sd32,  6'b100010, 8'd32, 6'b000110, 8'd0, 1'b0, 4'd3},  // R3
    '{-8'sd48,  6'b000110, 8'd32, 6'b000000, 8'd0, 1'b0, 4'd3},  // R3
    '{8'sd0,    6'b000011, 8'd32, 6'b010010, 8'd0, 1'b0, 4'd4},  // R4 zero, negative
    '{-8'sd35,  6'b100010, 8'd24, 6'b000110, 8'd2, 1'b0, 4'd6},  // R6 r=3
    '{-8'sd128, 6'b000110, 8'd32, 6'b000000, 8'd0, 1'b0, 4'd5}   // R5
  };

  function automatic string rq_name(input logic [3:0] c);
    case (c)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset and idle
    repeat (3) @(negedge clk_i);
    check("R1 in reset", int'(gate_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check("R1 enable low", int'(gate_o), 0);

    // R7: mid-period change waits for next valley
    @(negedge clk_i);
    ref_i = 8'sd16;
    en_i  = 1'b1;
    repeat (2*C + 6) @(posedge clk_i);
    @(negedge clk_i);
    ref_i = 8'sd32;
    repeat (2*C - 5) @(posedge clk_i);
    @(negedge clk_i);
    check("R7 old level held", int'(gate_o), 40);
    repeat (DEAD + 2) @(posedge clk_i);
    @(negedge clk_i);
    check("R7 new level after valley", int'(gate_o), 24);

    // table of steady-state vectors
    for (int i = 0; i < NV; i++) begin
      int lo, hi, pb;
      @(negedge clk_i);
      ref_i = VEC[i].r;
      repeat (6*C) @(negedge clk_i);
      lo = 0; hi = 0; pb = 0;
      for (int k = 0; k < 2*C; k++) begin
        @(negedge clk_i);
        if (gate_o == VEC[i].lo_p) lo++;
        if (gate_o == VEC[i].hi_p) hi++;
        if (VEC[i].pos ? (!gate_o[3] || gate_o[1]) : (!gate_o[1] || gate_o[3])) pb++;
      end
      check(rq_name(VEC[i].rq), lo, int'(VEC[i].lo_n));
      check(rq_name(VEC[i].rq), hi, int'(VEC[i].hi_n));
      check("R10 polarity leg", pb, 0);
    end

    // R1: enable drop mid-run, then resume
    @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    check("R1 disable", int'(gate_o), 0);
    repeat (4) @(negedge clk_i);
    check("R1 disabled hold", int'(gate_o), 0);
    en_i = 1'b1;
    repeat (4*C) @(negedge clk_i);
    check("R1 resume", int'(gate_o), 6);

    // R1: asynchronous reset mid-run
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", int'(gate_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    check("R8 dead-time violations", dt_viol, 0);
    check("R8 rises observed", int'(dt_rises > 10), 1);
    check("R9 leg exclusion", excl_viol, 0);
    finish_run();
  end
endmodule